// File: doc/BRIEF.md
# Stereo PDM Microphone Capture Interface

This block drives the bit clock for two pulse-density-modulated microphones that share one data wire, and turns the shared 1-bit stream into stereo PCM. The master clock runs at 128 times the frame rate. Dividing it by two gives a microphone clock at 64 times the frame rate, so each microphone clock phase lasts one master cycle. One microphone drives the wire during the high phase and the other drives it during the low phase. The block captures one bit at the end of each phase. A control input chooses which phase belongs to the left channel.

Each channel counts the ones in a window of 64 bits. It then maps that count linearly onto a signed 24-bit code, with saturation at the positive end. When both codes for a window are ready, the block raises a one-cycle strobe and presents the pair. The pair stays on the outputs until the next strobe.

A three-state sequencer sets the clock phase:
- `ST_OFF` keeps the microphone clock low and holds the counters cleared.
- `ST_HI` is the high phase.
- `ST_LO` is the low phase.

The transitions are:
- `ST_OFF` to `ST_HI` when the enable input is 1.
- `ST_HI` to `ST_LO` when the enable input is 1.
- `ST_LO` to `ST_HI` when the enable input is 1.
- Any state to `ST_OFF` when the enable input is 0.

Top module: `pdm_stereo_rx`

## Requirements
- R1: While `clk_en` is 1 and the sequencer is running, `mic_clk` inverts on every master clock cycle. This makes one microphone clock period two master cycles, which is 64 periods per frame.
- R2: Once `clk_en` has been 0 at a master clock edge, `mic_clk` is 0 after that edge and stays 0. No `pcm_valid` strobe occurs while the enable is off.
- R3: With `high_is_left` = 1, the bit present at the end of each `mic_clk` high phase counts toward the left channel. The bit present at the end of each low phase counts toward the right channel.
- R4: With `high_is_left` = 0, the mapping is swapped: high-phase bits go to the right channel and low-phase bits go to the left channel.
- R5: A window whose ones count is k (0..64) produces the two's-complement code (k − 32)·2^18. The exception is k = 64, which saturates to 24'h7FFFFF. All zeros gives 24'h800000 and k = 32 gives 0.
- R6: `pcm_valid` is high for exactly one master cycle per completed window. That cycle follows the master edge that captures the window's 64th low-phase bit. `pcm_left` and `pcm_right` change only in that cycle and hold otherwise.
- R7: After the enable goes from 0 to 1, the first window starts with the first `mic_clk` rising edge. Bits from a window that was cut short by disabling are discarded.
- R8: Asynchronous reset (`rst_n` = 0) leaves:
  - `mic_clk` at 0,
  - `pcm_valid` at 0,
  - both PCM outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 128 times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Enables the microphone clock and capture |
| high_is_left | input | 1 | 1: high phase is left; 0: high phase is right |
| pdm_data | input | 1 | Shared microphone data line |
| mic_clk | output | 1 | Microphone bit clock, low when disabled |
| pcm_valid | output | 1 | One-cycle strobe for a new stereo pair |
| pcm_left | output | 24 | Signed left-channel sample |
| pcm_right | output | 24 | Signed right-channel sample |

## Verification
The bench builds the block with its default window of 64 bits and 24-bit output. This puts both ends of the code range in reach: the saturated 24'h7FFFFF at full density and 24'h800000 at zero density. It also reaches asymmetric densities in each phase under both mapping settings.

Several sequences are driven beyond the single-window cases:
- Back-to-back windows exercise continuous running.
- A window is cut short by disabling and then re-enabled, which shows that partial counts are thrown away.
- A long disabled stretch shows that the clock stays low and no strobes appear.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_HI  = 2'd1,
        ST_LO  = 2'd2
    } mic_phase_e;

endpackage

// File: rtl/pdm_phase_seq.sv
module pdm_phase_seq
    import pdm_rx_pkg::*;
#(
    parameter int WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    output logic mic_clk,
    output logic hi_take,
    output logic lo_take,
    output logic win_done
);
    localparam int PW = $clog2(WINDOW);

    mic_phase_e      state_q, state_d;
    logic [PW-1:0]   pair_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = clk_en ? ST_HI : ST_OFF;
            ST_HI:   state_d = clk_en ? ST_LO : ST_OFF;
            ST_LO:   state_d = clk_en ? ST_HI : ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs: registered clock and pair position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mic_clk <= 1'b0;
            pair_q  <= '0;
        end else begin
            mic_clk <= (state_d == ST_HI);
            if (!clk_en)
                pair_q <= '0;
            else if (state_q == ST_LO)
                pair_q <= pair_q + 1'b1;
        end
    end

    assign hi_take  = clk_en && (state_q == ST_HI);
    assign lo_take  = clk_en && (state_q == ST_LO);
    assign win_done = lo_take && (pair_q == PW'(WINDOW - 1));

    // R2
    clk_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !mic_clk);

    // R1
    clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && mic_clk) |=> !mic_clk);

    // R1
    clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !mic_clk && $past(clk_en) && $past(mic_clk)) |=> (mic_clk || !clk_en));

endmodule

// File: rtl/pdm_ones_acc.sv
module pdm_ones_acc #(
    parameter int WINDOW = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          take,
    input  logic                          bit_in,
    input  logic                          win_done,
    output logic [$clog2(WINDOW+1)-1:0]   total
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0] cnt_q;
    logic          inc;

    assign inc   = take && bit_in;
    assign total = cnt_q + CW'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || win_done)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    // R5
    ones_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WINDOW));

    // R7
    acc_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/pdm_stereo_rx.sv
module pdm_stereo_rx #(
    parameter int WINDOW = 64,
    parameter int OUT_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             high_is_left,
    input  logic             pdm_data,
    output logic             mic_clk,
    output logic             pcm_valid,
    output logic [OUT_W-1:0] pcm_left,
    output logic [OUT_W-1:0] pcm_right
);
    localparam int CW    = $clog2(WINDOW + 1);
    localparam int SHIFT = OUT_W - $clog2(WINDOW);
    localparam int NCH   = 2;

    logic          hi_take, lo_take, win_done;
    logic [CW-1:0] tot [NCH];
    logic          take [NCH];

    pdm_phase_seq #(.WINDOW(WINDOW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .mic_clk  (mic_clk),
        .hi_take  (hi_take),
        .lo_take  (lo_take),
        .win_done (win_done)
    );

    // channel 0 = left, channel 1 = right
    assign take[0] = high_is_left ? hi_take : lo_take;
    assign take[1] = high_is_left ? lo_take : hi_take;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pdm_ones_acc #(.WINDOW(WINDOW)) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (!clk_en),
            .take     (take[c]),
            .bit_in   (pdm_data),
            .win_done (win_done),
            .total    (tot[c])
        );
    end

    function automatic logic [OUT_W-1:0] to_pcm(input logic [CW-1:0] k);
        logic signed [OUT_W+1:0] t;
        t = (signed'({{(OUT_W + 2 - CW){1'b0}}, k})
             - signed'((OUT_W + 2)'(WINDOW / 2))) <<< SHIFT;
        if (k >= CW'(WINDOW))
            return {1'b0, {(OUT_W - 1){1'b1}}};
        return t[OUT_W-1:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcm_valid <= 1'b0;
            pcm_left  <= '0;
            pcm_right <= '0;
        end else begin
            pcm_valid <= win_done;
            if (win_done) begin
                pcm_left  <= to_pcm(tot[0]);
                pcm_right <= to_pcm(tot[1]);
            end
        end
    end

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |=> !pcm_valid);

    // R6
    pcm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_valid |-> ($stable(pcm_left) && $stable(pcm_right)));

    // R2
    no_strobe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !pcm_valid);

endmodule

// File: tb/sim_pdm_stereo_rx.sv
module sim_pdm_stereo_rx;
    localparam int WINDOW = 64;
    localparam int OUT_W  = 24;
    localparam int NVEC   = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_en = 1'b0;
    logic             high_is_left = 1'b0;
    logic             pdm_data = 1'b0;
    logic             mic_clk;
    logic             pcm_valid;
    logic [OUT_W-1:0] pcm_left, pcm_right;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pdm_stereo_rx #(.WINDOW(WINDOW), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .high_is_left(high_is_left),
        .pdm_data(pdm_data), .mic_clk(mic_clk), .pcm_valid(pcm_valid),
        .pcm_left(pcm_left), .pcm_right(pcm_right)
    );

    // {high_is_left, ones in high phase, ones in low phase, expected left, expected right}
    localparam logic [62:0] VECS [NVEC] = '{
        {1'b1, 7'd64, 7'd0,  24'h7FFFFF, 24'h800000},
        {1'b0, 7'd64, 7'd0,  24'h800000, 24'h7FFFFF},
        {1'b1, 7'd32, 7'd33, 24'h000000, 24'h040000},
        {1'b0, 7'd31, 7'd63, 24'h7C0000, 24'hFC0000},
        {1'b1, 7'd1,  7'd48, 24'h840000, 24'h400000},
        {1'b0, 7'd0,  7'd0,  24'h800000, 24'h800000}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drives one window with the first hk high-phase bits and first lk low-phase bits at 1.
    // Starts on a negedge and ends on the negedge after the capture edge of the last bit.
    task automatic run_window(input int hk, input int lk, output int mid_strobes,
                              output int tog_err);
        logic prev;
        mid_strobes = 0;
        tog_err = 0;
        for (int w = 0; w < 4 && !mic_clk; w++) begin
            pdm_data = 1'b0;
            @(negedge clk);
        end
        prev = 1'b0;
        for (int p = 0; p < WINDOW; p++) begin
            if (mic_clk !== 1'b1 || prev !== 1'b0) tog_err++;
            pdm_data = (p < hk);
            @(negedge clk);
            if (pcm_valid) mid_strobes++;
            if (mic_clk !== 1'b0) tog_err++;
            prev = 1'b0;
            pdm_data = (p < lk);
            @(negedge clk);
            if (p != WINDOW - 1 && pcm_valid) mid_strobes++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int mid, tg, strobes;
        logic [OUT_W-1:0] el, er;

        // R8: reset state
        repeat (3) @(negedge clk);
        check(mic_clk === 1'b0, "R8", "mic_clk in reset", 32'(mic_clk), 0);
        check(pcm_valid === 1'b0 && pcm_left === '0 && pcm_right === '0, "R8",
              "outputs in reset", {7'd0, pcm_valid, pcm_left}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: disabled, clock held low, no strobes
        strobes = 0; tg = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (pcm_valid) strobes++;
            if (mic_clk !== 1'b0) tg++;
        end
        check(tg == 0, "R2", "mic_clk high while disabled", tg, 0);
        check(strobes == 0, "R2", "strobes while disabled", strobes, 0);

        // Vector table: R3, R4, R5, R6, R1
        for (int v = 0; v < NVEC; v++) begin
            high_is_left = VECS[v][62];
            el = VECS[v][47:24];
            er = VECS[v][23:0];
            clk_en = 1'b1;
            run_window(int'(VECS[v][61:55]), int'(VECS[v][54:48]), mid, tg);
            check(tg == 0, "R1", "mic_clk toggle pattern", tg, 0);
            check(mid == 0, "R6", "early strobe", mid, 0);
            check(pcm_valid === 1'b1, "R6", "strobe after window", 32'(pcm_valid), 1);
            check(pcm_left === el, high_is_left ? "R3" : "R4", "left sample", 32'(pcm_left), 32'(el));
            check(pcm_right === er, "R5", "right sample", 32'(pcm_right), 32'(er));
            clk_en = 1'b0;
            @(negedge clk);
            check(pcm_valid === 1'b0 && mic_clk === 1'b0, "R2", "after disable",
                  {30'd0, pcm_valid, mic_clk}, 0);
            check(pcm_left === el && pcm_right === er, "R6", "held sample",
                  32'(pcm_left), 32'(el));
            repeat (3) @(negedge clk);
        end

        // R6: back-to-back windows, strobes 128 cycles apart
        high_is_left = 1'b1;
        clk_en = 1'b1;
        run_window(64, 64, mid, tg);
        check(pcm_valid === 1'b1 && pcm_left === 24'h7FFFFF, "R6", "first of pair",
              32'(pcm_left), 32'h7FFFFF);
        run_window(16, 0, mid, tg);
        check(mid == 0 && tg == 0, "R6", "no extra strobe between windows", mid + tg, 0);
        check(pcm_valid === 1'b1 && pcm_left === 24'hC00000 && pcm_right === 24'h800000,
              "R5", "second window", 32'(pcm_left), 32'hC00000);
        clk_en = 1'b0;
        repeat (3) @(negedge clk);

        // R7: partial window discarded on re-enable
        clk_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            pdm_data = 1'b1;
            @(negedge clk);
        end
        clk_en = 1'b0;
        repeat (5) @(negedge clk);
        clk_en = 1'b1;
        run_window(0, 0, mid, tg);
        check(pcm_valid === 1'b1, "R7", "strobe after restart", 32'(pcm_valid), 1);
        check(pcm_left === 24'h800000 && pcm_right === 24'h800000, "R7",
              "partial bits discarded", 32'(pcm_left), 32'h800000);
        clk_en = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule